// File: doc/BRIEF.md
# Toeplitz Receive Hash Distributor

The block gives each received packet a steering group. It takes a header tuple one byte per cycle, with flags that mark the first and the last byte. It runs a Toeplitz hash over the tuple, using a 320-bit secret key that software writes as ten 32-bit words. The low six bits of the 32-bit hash select one of 64 entries in an indirection table, and that 4-bit entry is the group of the packet.

The accumulator is updated once per accepted byte. After the last byte, the block presents the hash, the table index and the group together for one cycle, marked by a valid pulse. A tuple longer than the supported maximum produces an error pulse and no result. Both the key and the table are loaded through simple write ports. Header parsing and the queues downstream are outside this block.

Top module: `rx_hash_steer`

## Requirements
- R1: During and after reset, `res_valid` and `res_err` are 0 and `res_hash`, `res_index` and `res_group` are 0 until the first result.
- R2: Key word w holds key bytes 4w to 4w+3, with byte 4w in bits 31:24. Key bit n (MSB-first across the key) is bit 31-(n mod 32) of word n/32.
- R3: For every input bit i that is set (MSB of the first byte is i=0), the 32-bit key window that starts at key bit i is XORed into the hash; `res_hash` is that XOR over the whole tuple.
- R4: `res_index` equals `res_hash[5:0]`.
- R5: `res_group` is the 4-bit table entry at `res_index`. A table write stores `tbl_wdata` at `tbl_addr`, and later results read the new value.
- R6: `res_valid` pulses for exactly one cycle, in the cycle after the clock edge that accepts a byte marked last. Back-to-back tuples of one byte each give one pulse per tuple.
- R7: A byte marked first discards any unfinished tuple and starts a new hash.
- R8: A tuple of more than 36 bytes pulses `res_err` in the cycle after its last byte, and `res_valid` stays 0.
- R9: A tuple of exactly 36 bytes produces a normal result.
- R10: Cycles with `in_valid` low inside a tuple do not affect the result.
- R11: Key writes to an address of 10 or above are ignored.
- R12: `res_hash`, `res_index` and `res_group` hold their values while `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Key word write strobe |
| key_addr | input | 4 | Key word number (0 to 9) |
| key_wdata | input | 32 | Key word data |
| tbl_we | input | 1 | Indirection table write strobe |
| tbl_addr | input | 6 | Indirection table entry |
| tbl_wdata | input | 4 | Group value written to the entry |
| in_valid | input | 1 | Tuple byte is present |
| in_first | input | 1 | Byte is the first of a tuple |
| in_last | input | 1 | Byte is the last of a tuple |
| in_byte | input | 8 | Tuple byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_err | output | 1 | One-cycle strobe for an oversize tuple |
| res_hash | output | 32 | Toeplitz hash of the tuple |
| res_index | output | 6 | Indirection table index |
| res_group | output | 4 | Selected steering group |

## Verification
The assertions assume that the bench holds the key steady while a tuple is in flight, because the hash uses whichever key is present as each byte arrives. They also assume that every table entry is written before a result reads it, and that `in_last` is low while reset is asserted. The stimulus loads the whole table first, changes the key only between tuples, and drives the reset with every input at 0. The reference model hashes each tuple in one pass at its last byte, so it depends on these same conditions.

// File: rtl/rhd_pkg.sv
package rhd_pkg;
  localparam int DEF_KEY_WORDS = 10;
  localparam int DEF_WORD_W    = 32;
  localparam int DEF_IDX_W     = 6;
  localparam int DEF_GRP_W     = 4;
  localparam int DEF_MAX_LEN   = 36;
endpackage

// File: rtl/rhd_key_bank.sv
module rhd_key_bank #(
  parameter int KEY_WORDS = rhd_pkg::DEF_KEY_WORDS,
  parameter int WORD_W    = rhd_pkg::DEF_WORD_W,
  localparam int KA_W     = $clog2(KEY_WORDS),
  localparam int KEY_BITS = KEY_WORDS * WORD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [KA_W-1:0]     addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [KEY_BITS-1:0] key_flat
);
  localparam logic [KA_W-1:0] LAST_A = KA_W'(KEY_WORDS - 1);

  logic [WORD_W-1:0] words [KEY_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < KEY_WORDS; w++) words[w] <= '0;
    end else if (we && addr <= LAST_A) begin
      words[addr] <= wdata;
    end
  end

  // word 0 sits at the top of the flat key so key bit 0 is its MSB
  for (genvar w = 0; w < KEY_WORDS; w++) begin : g_flat
    assign key_flat[KEY_BITS-1-w*WORD_W -: WORD_W] = words[w];
  end

  p_key_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    (we && addr > LAST_A) |=> $stable(key_flat));
endmodule

// File: rtl/rhd_hash_step.sv
module rhd_hash_step #(
  parameter int WORD_W   = rhd_pkg::DEF_WORD_W,
  localparam int SLICE_W = WORD_W + 8
) (
  input  logic [SLICE_W-1:0] slice,
  input  logic [7:0]         data,
  input  logic [WORD_W-1:0]  acc_in,
  output logic [WORD_W-1:0]  acc_out
);
  logic [WORD_W-1:0] term [8];

  for (genvar b = 0; b < 8; b++) begin : g_bit
    assign term[b] = data[7-b] ? slice[SLICE_W-1-b -: WORD_W] : '0;
  end

  always_comb begin
    acc_out = acc_in;
    for (int b = 0; b < 8; b++) acc_out = acc_out ^ term[b];
  end
endmodule

// File: rtl/rhd_ind_table.sv
module rhd_ind_table #(
  parameter int IDX_W  = rhd_pkg::DEF_IDX_W,
  parameter int GRP_W  = rhd_pkg::DEF_GRP_W,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [GRP_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [GRP_W-1:0] rdata
);
  logic [GRP_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  p_tbl_write_r5: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/rx_hash_steer.sv
module rx_hash_steer #(
  parameter int KEY_WORDS = rhd_pkg::DEF_KEY_WORDS,
  parameter int WORD_W    = rhd_pkg::DEF_WORD_W,
  parameter int IDX_W     = rhd_pkg::DEF_IDX_W,
  parameter int GRP_W     = rhd_pkg::DEF_GRP_W,
  parameter int MAX_LEN   = rhd_pkg::DEF_MAX_LEN,
  localparam int KA_W     = $clog2(KEY_WORDS),
  localparam int KEY_BITS = KEY_WORDS * WORD_W,
  localparam int SLICE_W  = WORD_W + 8,
  localparam int CNT_W    = $clog2(MAX_LEN + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_we,
  input  logic [KA_W-1:0]   key_addr,
  input  logic [WORD_W-1:0] key_wdata,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [GRP_W-1:0]  tbl_wdata,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [7:0]        in_byte,
  output logic              res_valid,
  output logic              res_err,
  output logic [WORD_W-1:0] res_hash,
  output logic [IDX_W-1:0]  res_index,
  output logic [GRP_W-1:0]  res_group
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_LEN);

  logic [KEY_BITS-1:0] key_flat;
  logic [CNT_W-1:0]    cnt, pos, pos_c;
  logic                in_pkt, ovf, take, ovf_nxt;
  logic [WORD_W-1:0]   acc, acc_base, acc_nxt;
  logic [SLICE_W-1:0]  slice;
  logic [GRP_W-1:0]    grp_rd;

  rhd_key_bank #(.KEY_WORDS(KEY_WORDS), .WORD_W(WORD_W)) u_keys (
    .clk(clk), .rst(rst), .we(key_we), .addr(key_addr),
    .wdata(key_wdata), .key_flat(key_flat));

  // byte position inside the tuple; positions past the limit clamp to 0
  assign take     = in_valid && (in_first || in_pkt);
  assign pos      = in_first ? '0 : cnt;
  assign pos_c    = (pos < MAX_C) ? pos : '0;
  assign slice    = key_flat[(KEY_BITS-1) - 8*int'(pos_c) -: SLICE_W];
  assign acc_base = in_first ? '0 : acc;
  assign ovf_nxt  = (!in_first && ovf) || (pos >= MAX_C);

  rhd_hash_step #(.WORD_W(WORD_W)) u_step (
    .slice(slice), .data(in_byte), .acc_in(acc_base), .acc_out(acc_nxt));

  rhd_ind_table #(.IDX_W(IDX_W), .GRP_W(GRP_W)) u_tbl (
    .clk(clk), .rst(rst), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .raddr(acc_nxt[IDX_W-1:0]), .rdata(grp_rd));

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt    <= 1'b0;
      ovf       <= 1'b0;
      cnt       <= '0;
      acc       <= '0;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      res_hash  <= '0;
      res_index <= '0;
      res_group <= '0;
    end else begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      if (take) begin
        if (in_last) begin
          in_pkt <= 1'b0;
          ovf    <= 1'b0;
          cnt    <= '0;
          if (ovf_nxt) begin
            res_err <= 1'b1;
          end else begin
            res_valid <= 1'b1;
            res_hash  <= acc_nxt;
            res_index <= acc_nxt[IDX_W-1:0];
            res_group <= grp_rd;
          end
        end else begin
          in_pkt <= 1'b1;
          acc    <= acc_nxt;
          ovf    <= ovf_nxt;
          cnt    <= (pos < MAX_C) ? pos + CNT_W'(1) : MAX_C;
        end
      end
    end
  end

  p_valid_cause_r6: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid && in_last));
  p_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && res_err));
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= MAX_C);
  p_index_low_r4: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_index == res_hash[IDX_W-1:0]);
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(res_hash) && $stable(res_group)));
endmodule

// File: tb/rx_hash_steer_bench.sv
module rx_hash_steer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_we = 1'b0, tbl_we = 1'b0;
  logic [3:0] key_addr = '0;
  logic [31:0] key_wdata = '0;
  logic [5:0] tbl_addr = '0;
  logic [3:0] tbl_wdata = '0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0] in_byte = '0;
  logic res_valid, res_err;
  logic [31:0] res_hash;
  logic [5:0] res_index;
  logic [3:0] res_group;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  rx_hash_steer u_rx_hash_steer (
    .clk(clk), .rst(rst), .key_we(key_we), .key_addr(key_addr),
    .key_wdata(key_wdata), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_byte(in_byte), .res_valid(res_valid),
    .res_err(res_err), .res_hash(res_hash), .res_index(res_index),
    .res_group(res_group));

  // reference model state
  logic [31:0] key_m [10];
  logic [3:0]  tbl_m [64];
  logic [7:0]  q [$];
  bit          active = 0;
  logic        e_valid = 0, e_err = 0;
  logic [31:0] e_hash = '0;
  logic [5:0]  e_idx = '0;
  logic [3:0]  e_grp = '0;

  function automatic logic [31:0] toep(input logic [7:0] d [$]);
    logic [31:0] h = '0;
    logic [31:0] w;
    for (int i = 0; i < d.size() * 8; i++) begin
      if (d[i/8][7 - i%8]) begin
        for (int k = 0; k < 32; k++) w[31-k] = key_m[(i+k)/32][31 - (i+k)%32];
        h = h ^ w;
      end
    end
    return h;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_valid = 0; e_err = 0; e_hash = '0; e_idx = '0; e_grp = '0;
      active = 0; q.delete();
      for (int w = 0; w < 10; w++) key_m[w] = '0;
    end else begin
      e_valid = 0; e_err = 0;
      if (in_valid && (in_first || active)) begin
        if (in_first) q.delete();
        q.push_back(in_byte);
        if (in_last) begin
          active = 0;
          if (q.size() > 36) e_err = 1;
          else begin
            e_valid = 1;
            e_hash  = toep(q);
            e_idx   = e_hash[5:0];
            e_grp   = tbl_m[e_idx];
          end
        end else active = 1;
      end
      if (key_we && key_addr < 10) key_m[key_addr] = key_wdata;
      if (tbl_we) tbl_m[tbl_addr] = tbl_wdata;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R6 valid strobe", 32'(res_valid), 32'(e_valid));
      check("R8 error strobe", 32'(res_err), 32'(e_err));
      check("R3 hash", res_hash, e_hash);
      check("R4 index", 32'(res_index), 32'(e_idx));
      check("R5 group", 32'(res_group), 32'(e_grp));
    end
  end

  task automatic wkey(input int a, input logic [31:0] v);
    @(negedge clk); key_we = 1; key_addr = 4'(a); key_wdata = v;
    @(negedge clk); key_we = 0;
  endtask

  task automatic wtbl(input int a, input logic [3:0] v);
    @(negedge clk); tbl_we = 1; tbl_addr = 6'(a); tbl_wdata = v;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic send(input logic [7:0] d [$], input int gap, input bit with_last);
    for (int i = 0; i < d.size(); i++) begin
      @(negedge clk);
      in_valid = 1; in_first = (i == 0);
      in_last = with_last && (i == d.size() - 1); in_byte = d[i];
      if (gap > 0 && i < d.size() - 1)
        repeat (gap) begin @(negedge clk); in_valid = 0; in_first = 0; end
    end
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
  endtask

  logic [7:0] vec [$];
  logic [7:0] vec4 [$];
  logic [7:0] tmp [$];
  logic [31:0] std_key [10];

  initial begin
    vec  = '{8'h42, 8'h09, 8'h95, 8'hbb, 8'ha1, 8'h8e, 8'h64, 8'h50,
             8'h0a, 8'hea, 8'h06, 8'he6};
    vec4 = '{8'h42, 8'h09, 8'h95, 8'hbb, 8'ha1, 8'h8e, 8'h64, 8'h50};
    std_key = '{32'h6d5a56da, 32'h255b0ec2, 32'h4167253d, 32'h43a38fb0,
                32'hd0ca2bcb, 32'hae7b30b4, 32'h77cb2da3, 32'h8030f20c,
                32'h6a42b73b, 32'hbeac01fa};
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(res_valid), 0);
    check("R1 reset err", 32'(res_err), 0);
    check("R1 reset hash", res_hash, 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check("R1 after reset group", 32'(res_group), 0);

    for (int i = 0; i < 64; i++) wtbl(i, 4'((i*7 + 3) & 15));

    // R2: only key bit 32 set; input bit 7 puts it at hash bit 6
    wkey(1, 32'h8000_0000);
    tmp = '{8'h01};
    send(tmp, 0, 1);
    check("R2 key bit order", res_hash, 32'h0000_0040);

    for (int w = 0; w < 10; w++) wkey(w, std_key[w]);
    send(vec, 0, 1);
    check("R3 public vector hash", res_hash, 32'h51ccc178);
    check("R4 index of vector", 32'(res_index), 32'h38);
    check("R5 group of vector", 32'(res_group), 32'd11);
    check("R6 pulse present", 32'(res_valid), 1);
    @(negedge clk);
    check("R6 pulse ended", 32'(res_valid), 0);
    check("R12 hash held", res_hash, 32'h51ccc178);

    send(vec4, 0, 1);
    check("R3 address-only vector", res_hash, 32'h323e8fc2);

    send(vec, 2, 1);
    check("R10 gaps ignored", res_hash, 32'h51ccc178);

    tmp = '{8'hff, 8'h13, 8'h77, 8'h01, 8'h80};
    send(tmp, 0, 0);
    send(vec, 0, 1);
    check("R7 restart on first", res_hash, 32'h51ccc178);

    tmp.delete();
    for (int i = 0; i < 36; i++) tmp.push_back(8'(i*37 + 5));
    send(tmp, 0, 1);
    check("R9 36-byte result", 32'(res_valid), 1);
    tmp.push_back(8'h5a);
    send(tmp, 0, 1);
    check("R8 oversize error", 32'(res_err), 1);
    check("R8 no result", 32'(res_valid), 0);

    wkey(12, 32'hffff_ffff);
    wkey(10, 32'h1234_5678);
    send(vec, 0, 1);
    check("R11 bad key address ignored", res_hash, 32'h51ccc178);

    wtbl(56, 4'h2);
    send(vec, 0, 1);
    check("R5 rewritten entry", 32'(res_group), 32'h2);

    @(negedge clk); in_valid = 1; in_first = 1; in_last = 1; in_byte = 8'h80;
    @(negedge clk); in_byte = 8'h03;
    @(negedge clk); in_valid = 0; in_first = 0; in_last = 0;
    check("R6 back-to-back second pulse", 32'(res_valid), 1);
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule